// File: doc/BRIEF.md
# Transmit Statistics Nibble Counters

This block keeps four small event counters that summarise how transmitted frames fared on the medium. A transmit engine sends a single-cycle pulse for each outcome it classifies: a frame that went out after exactly one collision, one that went out after several collisions, one that had to wait for carrier before starting, and one that waited longer than twice the maximum frame time. Each outcome has its own 4-bit counter. The four counters are packed into one 16-bit word that the host reads.

A counter that wraps from 15 to 0 sets a shared, sticky rollover flag. That flag drives an interrupt request only while the rollover interrupt enable input is high. A host read strobe returns the current word and clears all counters and the flag on the following edge, so the host can accumulate the counts in software without losing events. A status state machine holds the flag. It has two states. `ST_QUIET` means no counter has wrapped since the last read or reset. `ST_ROLLED` means at least one has. The transition `ST_QUIET -> ST_ROLLED` happens on any wrap. The transition `ST_ROLLED -> ST_QUIET` happens on a host read. Reset forces `ST_QUIET`.

Classifying the events is done upstream. A frame aborted after sixteen collisions disables the transmitter and is not reported here as a multiple-collision frame.

Top module: `txstat_counters`

## Requirements
- R1: Reset clears the counter word to 0x0000, clears the rollover flag and holds the interrupt low.
- R2: One pulse on an event input raises only its own nibble by exactly one on the next clock edge. Nibble positions in the word: bits 3:0 single-collision (event bit 0), bits 7:4 multiple-collision (event bit 1), bits 11:8 deferred (event bit 2), bits 15:12 excessively deferred (event bit 3).
- R3: Pulses on several event inputs in the same cycle are all counted on that same edge.
- R4: A counter at 15 that receives a pulse becomes 0, leaves the other nibbles unchanged, and sets the rollover flag (state `ST_ROLLED`) on the same edge.
- R5: Once set, the rollover flag stays set through later events and idle cycles until a host read or reset.
- R6: The interrupt output is high exactly when the rollover flag is set and the enable input is high. With the enable low, a rollover never raises the interrupt.
- R7: During a read cycle the word still shows the uncleared count. On the next edge all four counters and the rollover flag are cleared.
- R8: An event pulse in the same cycle as a read is counted into the cleared value, so that nibble reads 1 after the edge.
- R9: A counter at 15 that gets a pulse in a read cycle becomes 1 and does not set the rollover flag.
- R10: Raising the enable while the flag is already set raises the interrupt in the same cycle, with no new wrap needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 4 | One-cycle outcome pulses: bit0 single coll., bit1 multi coll., bit2 deferred, bit3 excessive deferral |
| host_rd | input | 1 | Host read strobe for the counter word |
| roll_irq_en | input | 1 | Rollover interrupt enable |
| stat_word | output | 16 | Packed nibble counters |
| roll_flag | output | 1 | Sticky rollover status |
| roll_irq | output | 1 | Gated rollover interrupt request |

## Verification
The bench first sends pulses on one event input at a time. This tells whether each nibble sits at its stated position and moves by exactly one. It then drives all four inputs together, which shows whether simultaneous events interfere. Reads are applied both with no event and with an event in the same cycle, which separates clear-then-count from count-then-clear. Long runs of pulses on one counter reach the wrap. These runs are done once with a plain pulse, to show the flag and its gating by the enable, and once with the wrapping pulse landing on a read, to show that a cleared counter never reports a rollover.

// File: rtl/txstat_pkg.sv
package txstat_pkg;
    parameter int unsigned NUM_CTR = 4;
    parameter int unsigned CTR_W   = 4;

    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_ROLLED = 1'b1
    } roll_state_e;
endpackage

// File: rtl/txstat_nibble_ctr.sv
module txstat_nibble_ctr #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ev,
    input  logic         clr,
    output logic [W-1:0] count,
    output logic         wrap
);
    localparam logic [W-1:0] CMAX = {W{1'b1}};

    logic [W-1:0] base;

    always_comb begin
        base = clr ? '0 : count;
        wrap = ev && !clr && (count == CMAX);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= base + {{(W-1){1'b0}}, ev};
        end
    end

    // R2: an idle cycle without read leaves the count alone
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev && !clr) |=> $stable(count));
    // R2: a pulse without read steps the count by one below the top
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && !clr && count != CMAX) |=> (count == $past(count) + 1'b1));
    // R4: a pulse at the top value returns to zero
    assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && !clr && count == CMAX) |=> (count == '0));
    // R8: a read with a pulse leaves exactly one
    assert_read_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && ev) |=> (count == {{(W-1){1'b0}}, 1'b1}));
    // R7: a read without a pulse leaves zero
    assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ev) |=> (count == '0));
endmodule

// File: rtl/txstat_roll_fsm.sv
module txstat_roll_fsm
    import txstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_wrap,
    input  logic host_rd,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    roll_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_QUIET:  if (any_wrap) state_nx = ST_ROLLED;
            ST_ROLLED: if (host_rd && !any_wrap) state_nx = ST_QUIET;
            default:   state_nx = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_QUIET;
        else        state <= state_nx;
    end

    always_comb begin
        flag = (state == ST_ROLLED);
        irq  = flag && irq_en;
    end

    // R4: any wrap sets the flag on the same edge
    assert_wrap_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        any_wrap |=> flag);
    // R5: the flag persists until a read
    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !host_rd) |=> flag);
    // R7: a read drops the flag (no wrap can coincide with a read)
    assert_read_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> !flag);
endmodule

// File: rtl/txstat_counters.sv
module txstat_counters
    import txstat_pkg::*;
#(
    parameter int unsigned N_CTR = NUM_CTR,
    parameter int unsigned C_W   = CTR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_CTR-1:0]     evt_pulse,
    input  logic                 host_rd,
    input  logic                 roll_irq_en,
    output logic [N_CTR*C_W-1:0] stat_word,
    output logic                 roll_flag,
    output logic                 roll_irq
);
    localparam int unsigned WORD_W = N_CTR * C_W;

    logic [N_CTR-1:0] wrap_vec;

    for (genvar g = 0; g < N_CTR; g++) begin : g_ctr
        txstat_nibble_ctr #(.W(C_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .ev    (evt_pulse[g]),
            .clr   (host_rd),
            .count (stat_word[g*C_W +: C_W]),
            .wrap  (wrap_vec[g])
        );
    end

    txstat_roll_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_wrap (|wrap_vec),
        .host_rd  (host_rd),
        .irq_en   (roll_irq_en),
        .flag     (roll_flag),
        .irq      (roll_irq)
    );

    // R6: no interrupt while disabled
    assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !roll_irq_en |-> !roll_irq);
    // R6: interrupt implies the flag
    assert_irq_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        roll_irq |-> roll_flag);
    // R1: the cycle after reset the word is zero
    assert_reset_word_R1: assert property (@(posedge clk)
        !rst_n |=> (stat_word == '0 && !roll_flag));
    // R9: a read cycle never produces a wrap
    assert_no_wrap_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |-> (wrap_vec == '0));
    if (WORD_W == 0) begin : g_bad
        initial $display("txstat_counters: empty word");
    end
endmodule

// File: tb/tb_txstat_counters.sv
`timescale 1ns/1ps
module tb_txstat_counters;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  evt_pulse;
    logic        host_rd;
    logic        roll_irq_en;
    logic [15:0] stat_word;
    logic        roll_flag;
    logic        roll_irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    txstat_counters dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_pulse   (evt_pulse),
        .host_rd     (host_rd),
        .roll_irq_en (roll_irq_en),
        .stat_word   (stat_word),
        .roll_flag   (roll_flag),
        .roll_irq    (roll_irq)
    );

    // ev[23:20] rd[19] en[18] word[17:2] flag[1] irq[0]
    localparam logic [23:0] VEC [8] = '{
        {4'h1, 1'b0, 1'b0, 16'h0001, 1'b0, 1'b0},   // R2 single
        {4'h2, 1'b0, 1'b0, 16'h0011, 1'b0, 1'b0},   // R2 multi
        {4'h4, 1'b0, 1'b0, 16'h0111, 1'b0, 1'b0},   // R2 deferred
        {4'h8, 1'b0, 1'b0, 16'h1111, 1'b0, 1'b0},   // R2 excessive
        {4'hF, 1'b0, 1'b0, 16'h2222, 1'b0, 1'b0},   // R3 all together
        {4'hF, 1'b0, 1'b0, 16'h3333, 1'b0, 1'b0},   // R3 again
        {4'h0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0},   // R7 read clears
        {4'h5, 1'b1, 1'b0, 16'h0101, 1'b0, 1'b0}    // R8 read with events
    };

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(logic [3:0] ev, logic rd, logic en);
        @(negedge clk);
        evt_pulse   = ev;
        host_rd     = rd;
        roll_irq_en = en;
        @(posedge clk);
        #2;
    endtask

    task automatic idle(logic en);
        step(4'h0, 1'b0, en);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; evt_pulse = '0; host_rd = 1'b0; roll_irq_en = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check("R1 word", stat_word, 16'h0000);
        check("R1 flag/irq", {14'd0, roll_flag, roll_irq}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 8; i++) begin
            step(VEC[i][23:20], VEC[i][19], VEC[i][18]);
            check($sformatf("R2/R3/R7/R8 vec%0d word", i), stat_word, VEC[i][17:2]);
            check($sformatf("R5/R6 vec%0d flag/irq", i),
                  {14'd0, roll_flag, roll_irq}, {14'd0, VEC[i][1:0]});
        end

        // clear, then run deferred counter to the top
        step(4'h0, 1'b1, 1'b0);
        check("R7 cleared", stat_word, 16'h0000);
        for (int i = 0; i < 15; i++) step(4'h4, 1'b0, 1'b0);
        check("R4 at top", stat_word, 16'h0F00);
        check("R4 no flag yet", {15'd0, roll_flag}, 16'h0000);
        step(4'h4, 1'b0, 1'b0);
        check("R4 wrapped word", stat_word, 16'h0000);
        check("R4 flag set", {15'd0, roll_flag}, 16'h0001);
        check("R6 irq masked", {15'd0, roll_irq}, 16'h0000);
        idle(1'b0);
        check("R5 flag held idle", {15'd0, roll_flag}, 16'h0001);
        @(negedge clk);
        roll_irq_en = 1'b1;
        #1;
        check("R10 irq on enable", {15'd0, roll_irq}, 16'h0001);
        step(4'h1, 1'b0, 1'b1);
        check("R5 flag held on event", {14'd0, roll_flag, roll_irq}, 16'h0003);
        check("R2 after wrap", stat_word, 16'h0001);

        // read: pre-edge value still visible
        @(negedge clk);
        host_rd = 1'b1; evt_pulse = 4'h0; roll_irq_en = 1'b1;
        #1;
        check("R7 pre-clear value", stat_word, 16'h0001);
        @(posedge clk);
        #2;
        check("R7 post-clear word", stat_word, 16'h0000);
        check("R7 flag/irq cleared", {14'd0, roll_flag, roll_irq}, 16'h0000);

        // R9: wrap pulse landing on a read
        for (int i = 0; i < 15; i++) step(4'h8, 1'b0, 1'b1);
        check("R9 at top", stat_word, 16'hF000);
        step(4'h8, 1'b1, 1'b1);
        check("R9 word", stat_word, 16'h1000);
        check("R9 no flag", {14'd0, roll_flag, roll_irq}, 16'h0000);

        // wrap again then reset mid-run
        for (int i = 0; i < 15; i++) step(4'h8, 1'b0, 1'b1);
        check("R4 second wrap", {stat_word[15:12], 10'd0, roll_flag, roll_irq}, 16'h0003);
        @(negedge clk);
        rst_n = 1'b0; evt_pulse = 4'h3; host_rd = 1'b0;
        @(posedge clk);
        #2;
        check("R1 reset word", stat_word, 16'h0000);
        check("R1 reset flag/irq", {14'd0, roll_flag, roll_irq}, 16'h0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule